// File: doc/BRIEF.md
# Character Clock Dot Divider

This block sits at the front of a VGA-style display pipeline and turns the pixel dot clock into a character-clock enable. Each clock edge is one input dot. A small set of mode pins decides how many input clocks make up one character cell: 8 or 9 dots at the normal rate, 16 or 18 input clocks when the dot rate is halved, or a single clock when the display path is blanked. The block issues a one-cycle strobe on the last input clock of every cell, gives the index of the current dot within the cell, raises a flag during the extra ninth dot, and reports the active cell width so that downstream horizontal timing can scale its counts.

Text mode holds only when both the graphics-controller mode bit and the attribute-controller mode bit are clear. The 9-dot choice is used only in text mode. In graphics mode it is ignored and the width depends on the half-rate pin alone. The mode pins are sampled only at a cell boundary, so a cell in progress always runs to its full width. All pins are plain control and status levels. The block has no streaming interface, so it has no valid/ready handshake and no back-pressure.

Top module: `char_clk_divider`

## Requirements
- R1: In text mode (`gfx_mode_sel`=0 and `attr_gfx_sel`=0, neither blanked nor palette-disabled, `half_dot_rate`=0), `dots_per_char` reads 8 when `sel_eight_dot`=1 and 9 when `sel_eight_dot`=0.
- R2: With `half_dot_rate`=1 and the path not blanked, the cell width doubles to 16 or 18 input clocks. Each dot index is held for two consecutive clocks, starting from index 0.
- R3: If either `gfx_mode_sel` or `attr_gfx_sel` is 1, `sel_eight_dot` has no effect. `dots_per_char` is 16 when `half_dot_rate`=1 and 8 otherwise, and `ninth_dot` stays 0.
- R4: When `screen_blank`=1 or `palette_en`=0, `dots_per_char` is 1 and `half_dot_rate` is ignored. `char_stb` is 1 on every clock, and `dot_idx` stays 0.
- R5: `char_stb` is high for exactly one clock, which is the last input clock of a cell. On the following clock `dot_idx` is 0.
- R6: A change on any mode pin alters `dots_per_char` and the cell width only from the clock after a `char_stb` (or after reset). A cell is never cut short or stretched.
- R7: `ninth_dot` is 1 only while `dot_idx` is 8 in a 9-dot text cell, at either dot rate.
- R8: While `rst` is 1, `char_stb` is 0 and `dot_idx` is 0. The cell width is reloaded from the mode pins on every reset clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, one edge per input dot |
| rst | input | 1 | Synchronous reset, active high |
| gfx_mode_sel | input | 1 | Graphics-controller mode bit, 1 = graphics |
| attr_gfx_sel | input | 1 | Attribute-controller mode bit, 1 = graphics |
| sel_eight_dot | input | 1 | 1 = 8-dot cells, 0 = 9-dot cells (text mode only) |
| half_dot_rate | input | 1 | 1 = each dot held for two clocks |
| screen_blank | input | 1 | 1 = display blanked |
| palette_en | input | 1 | 1 = attribute palette path enabled |
| char_stb | output | 1 | One-clock strobe on the last clock of a cell |
| dot_idx | output | IDX_W (4) | Dot position within the current cell |
| ninth_dot | output | 1 | High during the ninth dot of a 9-dot text cell |
| dots_per_char | output | DPC_W (5) | Active cell width in input clocks, binary |

## Verification
The bench builds the block with its default base width of 8 dots. This gives all four cell widths (8, 9, 16, 18) and the forced width of 1, so the dot index reaches its top value of 8 and the 5-bit width output reaches 18. The reference model steps through every mode, including mode pins that toggle in the middle of a cell. It therefore exercises the cell-boundary rule with every pair of old and new widths, and it also exercises a reset that arrives partway through a half-rate cell.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  // Cell configuration latched at every cell boundary
  typedef struct packed {
    logic blanked;  // width forced to one clock
    logic half;     // each dot held for two clocks
    logic nine;     // text mode with the extra ninth dot
  } ccd_cfg_t;

endpackage

// File: rtl/ccd_mode_decode.sv
module ccd_mode_decode
  import ccd_pkg::*;
(
  input  logic     gfx_mode_sel,
  input  logic     attr_gfx_sel,
  input  logic     sel_eight_dot,
  input  logic     half_dot_rate,
  input  logic     screen_blank,
  input  logic     palette_en,
  output ccd_cfg_t cfg
);

  logic text_mode;
  logic blanked;

  always_comb begin
    text_mode   = !gfx_mode_sel && !attr_gfx_sel;
    blanked     = screen_blank || !palette_en;
    cfg.blanked = blanked;
    // the rate halving has no meaning when each cell is a single clock
    cfg.half    = half_dot_rate && !blanked;
    // the 9-dot choice counts only in text mode
    cfg.nine    = text_mode && !sel_eight_dot && !blanked;
  end

endmodule

// File: rtl/ccd_cell_counter.sv
module ccd_cell_counter
  import ccd_pkg::*;
#(
  parameter int BASE_DOTS = 8,
  parameter int IDX_W     = $clog2(BASE_DOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  ccd_cfg_t         cfg_next,
  output ccd_cfg_t         cfg_q,
  output logic [IDX_W-1:0] dot_q,
  output logic             cell_end
);

  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(BASE_DOTS - 1);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(BASE_DOTS);

  logic             phase_q;
  logic [IDX_W-1:0] last_idx;
  logic             last_dot;
  logic             last_phase;

  always_comb begin
    if (cfg_q.blanked)   last_idx = '0;
    else if (cfg_q.nine) last_idx = LAST_WIDE;
    else                 last_idx = LAST_NARROW;
    last_dot   = (dot_q == last_idx);
    last_phase = !cfg_q.half || phase_q;
    cell_end   = last_dot && last_phase;
  end

  always_ff @(posedge clk) begin
    if (rst || cell_end) begin
      cfg_q   <= cfg_next;
      dot_q   <= '0;
      phase_q <= 1'b0;
    end else if (cfg_q.half && !phase_q) begin
      phase_q <= 1'b1;
    end else begin
      phase_q <= 1'b0;
      dot_q   <= dot_q + 1'b1;
    end
  end

  // R5
  cell_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cell_end |=> (dot_q == '0));

  // R2
  half_rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.half && !phase_q) |=> $stable(dot_q));

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (dot_q == '0));

endmodule

// File: rtl/ccd_out_stage.sv
module ccd_out_stage
  import ccd_pkg::*;
#(
  parameter int BASE_DOTS = 8,
  parameter int IDX_W     = $clog2(BASE_DOTS + 1),
  parameter int DPC_W     = $clog2(2 * (BASE_DOTS + 1) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  ccd_cfg_t         cfg_q,
  input  logic [IDX_W-1:0] dot_q,
  input  logic             cell_end,
  output logic             char_stb,
  output logic             ninth_dot,
  output logic [DPC_W-1:0] dots_per_char
);

  localparam logic [DPC_W-1:0] W_NARROW = DPC_W'(BASE_DOTS);
  localparam logic [DPC_W-1:0] W_WIDE   = DPC_W'(BASE_DOTS + 1);
  localparam logic [IDX_W-1:0] IDX_NINE = IDX_W'(BASE_DOTS);

  logic [DPC_W-1:0] base_w;

  always_comb begin
    base_w    = cfg_q.nine ? W_WIDE : W_NARROW;
    if (cfg_q.blanked)   dots_per_char = DPC_W'(1);
    else if (cfg_q.half) dots_per_char = base_w << 1;
    else                 dots_per_char = base_w;
    char_stb  = cell_end && !rst;
    ninth_dot = cfg_q.nine && (dot_q == IDX_NINE);
  end

  // R7
  ninth_position_chk: assert property (@(posedge clk) disable iff (rst)
    ninth_dot |-> (dot_q == IDX_NINE && dots_per_char[0] == 1'b0 ? cfg_q.half : 1'b1));

  // R4
  blank_single_chk: assert property (@(posedge clk) disable iff (rst)
    (dots_per_char == DPC_W'(1)) |-> (char_stb && dot_q == '0));

endmodule

// File: rtl/char_clk_divider.sv
module char_clk_divider
  import ccd_pkg::*;
#(
  parameter int BASE_DOTS = 8,
  parameter int IDX_W     = $clog2(BASE_DOTS + 1),
  parameter int DPC_W     = $clog2(2 * (BASE_DOTS + 1) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gfx_mode_sel,
  input  logic             attr_gfx_sel,
  input  logic             sel_eight_dot,
  input  logic             half_dot_rate,
  input  logic             screen_blank,
  input  logic             palette_en,
  output logic             char_stb,
  output logic [IDX_W-1:0] dot_idx,
  output logic             ninth_dot,
  output logic [DPC_W-1:0] dots_per_char
);

  ccd_cfg_t cfg_next;
  ccd_cfg_t cfg_q;
  logic     cell_end;

  ccd_mode_decode u_decode (
    .gfx_mode_sel  (gfx_mode_sel),
    .attr_gfx_sel  (attr_gfx_sel),
    .sel_eight_dot (sel_eight_dot),
    .half_dot_rate (half_dot_rate),
    .screen_blank  (screen_blank),
    .palette_en    (palette_en),
    .cfg           (cfg_next)
  );

  ccd_cell_counter #(
    .BASE_DOTS (BASE_DOTS),
    .IDX_W     (IDX_W)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .cfg_next (cfg_next),
    .cfg_q    (cfg_q),
    .dot_q    (dot_idx),
    .cell_end (cell_end)
  );

  ccd_out_stage #(
    .BASE_DOTS (BASE_DOTS),
    .IDX_W     (IDX_W),
    .DPC_W     (DPC_W)
  ) u_out (
    .clk           (clk),
    .rst           (rst),
    .cfg_q         (cfg_q),
    .dot_q         (dot_idx),
    .cell_end      (cell_end),
    .char_stb      (char_stb),
    .ninth_dot     (ninth_dot),
    .dots_per_char (dots_per_char)
  );

  // R6
  width_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(char_stb)) |-> $stable(dots_per_char));

  // R5
  dot_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    dot_idx <= IDX_W'(BASE_DOTS));

endmodule

// File: tb/char_clk_divider_bench.sv
module char_clk_divider_bench;

  localparam int BASE = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gfx_mode_sel = 1'b0, attr_gfx_sel = 1'b0, sel_eight_dot = 1'b0;
  logic       half_dot_rate = 1'b0, screen_blank = 1'b0, palette_en = 1'b1;
  logic       char_stb, ninth_dot;
  logic [3:0] dot_idx;
  logic [4:0] dots_per_char;

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt = 0, m_w = 1, m_half = 0, m_nine = 0;

  always #10 clk = ~clk;

  char_clk_divider u_char_clk_divider (
    .clk(clk), .rst(rst), .gfx_mode_sel(gfx_mode_sel), .attr_gfx_sel(attr_gfx_sel),
    .sel_eight_dot(sel_eight_dot), .half_dot_rate(half_dot_rate),
    .screen_blank(screen_blank), .palette_en(palette_en),
    .char_stb(char_stb), .dot_idx(dot_idx), .ninth_dot(ninth_dot),
    .dots_per_char(dots_per_char)
  );

  // cell setup the requirements prescribe for the present pins
  task automatic decode(output int w, output int h, output int n);
    bit blank, text;
    blank = screen_blank || !palette_en;
    text  = !gfx_mode_sel && !attr_gfx_sel;
    n = (!blank && text && !sel_eight_dot) ? 1 : 0;
    h = (!blank && half_dot_rate) ? 1 : 0;
    w = blank ? 1 : ((n ? BASE + 1 : BASE) * (h ? 2 : 1));
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference model, stepped on each edge, compared a quarter period later
  always @(posedge clk) begin
    int w, h, n, exp_dot, cw, chh, cn;
    cycles++;
    if (rst || m_cnt == m_w - 1) begin
      decode(w, h, n);
      m_w = w; m_half = h; m_nine = n; m_cnt = 0;
    end else begin
      m_cnt++;
    end
    #5;
    decode(cw, chh, cn);
    exp_dot = m_half ? m_cnt / 2 : m_cnt;
    if (rst) begin
      check("R8 strobe in reset", int'(char_stb), 0);
      check("R8 dot index in reset", int'(dot_idx), 0);
    end else begin
      check("R5 strobe", int'(char_stb), (m_cnt == m_w - 1) ? 1 : 0);
      check(m_half ? "R2 dot index" : "R5 dot index", int'(dot_idx), exp_dot);
      check("R7 ninth dot", int'(ninth_dot), (m_nine && exp_dot == BASE) ? 1 : 0);
    end
    if (cw != m_w)          check("R6 width held to boundary", int'(dots_per_char), m_w);
    else if (m_w == 1)      check("R4 blanked width", int'(dots_per_char), m_w);
    else if (m_nine == 0 && (gfx_mode_sel || attr_gfx_sel))
                            check("R3 graphics width", int'(dots_per_char), m_w);
    else if (m_half)        check("R2 half-rate width", int'(dots_per_char), m_w);
    else                    check("R1 text width", int'(dots_per_char), m_w);
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  task automatic set_mode(input bit g, input bit a, input bit e, input bit h,
                          input bit b, input bit p);
    gfx_mode_sel = g; attr_gfx_sel = a; sel_eight_dot = e;
    half_dot_rate = h; screen_blank = b; palette_en = p;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    run(40);                          // R1 9-dot text
    set_mode(0, 0, 1, 0, 0, 1); run(40);  // R1 8-dot text
    set_mode(0, 0, 0, 1, 0, 1); run(60);  // R2 18-clock text, R7
    set_mode(0, 0, 1, 1, 0, 1); run(50);  // R2 16-clock text
    set_mode(1, 0, 0, 0, 0, 1); run(40);  // R3 graphics ignores 9-dot
    set_mode(0, 1, 0, 1, 0, 1); run(50);  // R3 graphics half rate
    set_mode(0, 0, 0, 1, 1, 1); run(20);  // R4 blanked
    set_mode(0, 0, 0, 0, 0, 0); run(20);  // R4 palette disabled
    set_mode(0, 0, 0, 1, 0, 1); run(7);   // R8 reset partway through a cell
    rst = 1'b1; run(2); rst = 1'b0; run(30);
    for (int k = 0; k < 3000; k++) begin  // R6 pins toggling mid-cell
      if ($urandom_range(0, 6) == 0)
        set_mode($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) != 0);
      @(negedge clk);
    end
    finish_run();
  end

endmodule